// File: doc/BRIEF.md
# Receiver Self-Test Pattern Checker

This block sits at the end of a serial link receiver's decode path, after 8b/10b decoding. It takes one decoded symbol per byte clock: an 8-bit value, a flag that marks a special character, and a decoder violation flag. Every result it produces is registered on the recovered byte clock, so a FIFO or other downstream logic sees clean, glitch-free outputs.

In normal mode the block is a plain output register. It captures each valid symbol and passes the decoder's violation flag to the error output.

In test mode a 9-bit pseudo-random generator runs next to that register. The generator waits for the loop-start code, which is the data symbol with value zero. That code seeds it. From then on, each symbol already held in the output register is fed back and compared with the locally generated symbol:

- A mismatch raises the error output for one cycle.
- Decoder violations are ignored in this mode.
- A ready pulse marks each completed 511-symbol loop.

The only way to re-seed the generator is to leave test mode and enter it again.

Top module: `rx_bist_checker`

## Requirements
- R1: On every clock edge where `in_valid` is high, `out_data` and `out_special` take the input symbol. They hold their value otherwise. All outputs are 0 after reset.
- R2: In normal mode (`test_en` low), `out_err` takes `in_viol` with each valid symbol and holds otherwise. `out_ready` stays 0.
- R3: The 9-bit symbol is {special, data[7:0]}. The generator starts at 0x1FF and steps as next = {s[7:0], s[8]^s[4]}, which is the polynomial x^9+x^5+1. It repeats every 511 symbols and never produces 0.
- R4: In test mode, before the loop-start code is seen, `out_err` and `out_ready` stay 0 for any input, including `in_viol`.
- R5: The loop-start code is a valid symbol with special=0 and data=0x00. It seeds the generator and is not itself compared. The next valid symbol is compared with 0x1FF.
- R6: In test mode, a valid symbol captured at edge k that differs from the expected symbol drives `out_err` high for exactly the cycle after edge k+1. In every other test-mode cycle `out_err` is 0.
- R7: While test mode is active, `in_viol` has no effect on `out_err`.
- R8: `out_ready` pulses high for one cycle, with the same timing as `out_err`, for every 511th symbol compared since the start code.
- R9: A loop-start code received after the loop has started does not re-seed the generator. It is compared like any other symbol, so it reports a mismatch.
- R10: Dropping `test_en` abandons the loop. On re-entry the checker waits for a new start code, then compares against the sequence from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered byte clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| test_en | input | 1 | Selects self-test mode when high |
| in_valid | input | 1 | Decoded symbol present this cycle |
| in_data | input | 8 | Decoded byte value |
| in_special | input | 1 | High for a special character, low for data |
| in_viol | input | 1 | Decoder code-rule or disparity violation |
| out_data | output | 8 | Registered byte |
| out_special | output | 1 | Registered special/data flag |
| out_err | output | 1 | Violation (normal mode) or mismatch (test mode) |
| out_ready | output | 1 | One-cycle pulse per completed loop |

## Verification
Timing is counted from a symbol captured at edge k:
- `out_data` and `out_special` are updated at edge k.
- In normal mode, `out_err` is updated at edge k.
- In test mode, the mismatch and loop-complete results for that symbol are updated one edge later, at k+1.

The bench keeps a behavioural model that decides each symbol's verdict as soon as the symbol arrives and holds that verdict in a one-cycle pending slot. It compares all four outputs with the model at every falling edge, which lies midway between updates. A late or early result therefore fails in the cycle where it appears.

// File: rtl/rxb_pkg.sv
// Shared types for the receiver self-test checker.
package rxb_pkg;
    // Checker mode: plain output register, armed (waiting for start code), running.
    typedef enum logic [1:0] {
        MODE_NORM  = 2'd0,
        MODE_ARMED = 2'd1,
        MODE_RUN   = 2'd2
    } bist_mode_e;
endpackage

// File: rtl/rxb_ctrl.sv
// Mode controller. Tracks normal, armed and running states, detects the
// loop-start code (a data symbol of value zero) and marks which captured
// symbols must be compared on the following edge.
// Assumes test_en is sampled on the same byte clock as the data.
module rxb_ctrl
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_special,
    output logic              seed_load,
    output logic              running,
    output logic              cmp_pend
);
    bist_mode_e mode_q;
    logic       start_hit;

    // Start code: valid data symbol with an all-zero value.
    assign start_hit = in_valid && !in_special && (in_data == '0);
    // Seed only while not already running, so repeats inside a loop are ignored.
    assign seed_load = test_en && (mode_q != MODE_RUN) && start_hit;
    assign running   = (mode_q == MODE_RUN);

    // Mode register: exit on test_en low, run on start code, arm on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORM;
        end else if (!test_en) begin
            mode_q <= MODE_NORM;
        end else if (seed_load) begin
            mode_q <= MODE_RUN;
        end else if (mode_q == MODE_NORM) begin
            mode_q <= MODE_ARMED;
        end
    end

    // Compare marker: a symbol captured while running is checked next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_pend <= 1'b0;
        end else begin
            cmp_pend <= test_en && running && in_valid;
        end
    end

    // R5: a start code always leads into the running state.
    assert_seed_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> running);

    // R10: leaving test mode abandons the loop and any pending compare.
    assert_exit_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (!running && !cmp_pend));

    // R9: once running with test mode held, the loop is never re-seeded.
    assert_no_reseed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && test_en) |=> running || !$past(test_en));
endmodule

// File: rtl/rxb_gen.sv
// Pseudo-random symbol generator and loop position counter.
// Fibonacci LFSR shifting left; the feedback bit is the XOR of two taps.
// Assumes seed_load and step never arrive together (the controller keeps
// them apart); seed_load takes priority if they do.
module rxb_gen #(
    parameter int               SYM_W    = 9,
    parameter logic [SYM_W-1:0] SEED     = '1,
    parameter int               TAP_HI   = 8,
    parameter int               TAP_LO   = 4,
    parameter int               LOOP_LEN = (1 << SYM_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic             step,
    output logic [SYM_W-1:0] exp_sym,
    output logic             wrap
);
    localparam int CNT_W = $clog2(LOOP_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOOP_LEN - 1);

    logic [SYM_W-1:0] lfsr_q;
    logic [SYM_W-1:0] lfsr_nxt;
    logic [CNT_W-1:0] cnt_q;

    // Next state: shift left, feed the tap XOR into bit 0.
    assign lfsr_nxt = {lfsr_q[SYM_W-2:0], lfsr_q[TAP_HI] ^ lfsr_q[TAP_LO]};
    assign exp_sym  = lfsr_q;
    assign wrap     = (cnt_q == LAST);

    // Generator state: reseed on start, advance once per compared symbol.
    always_ff @(posedge clk) begin
        if (!rst_n || seed_load) begin
            lfsr_q <= SEED;
        end else if (step) begin
            lfsr_q <= lfsr_nxt;
        end
    end

    // Loop position: counts compared symbols modulo the loop length.
    always_ff @(posedge clk) begin
        if (!rst_n || seed_load) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // R3: a maximal-length generator never reaches the all-zero state.
    assert_state_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R5: seeding places the generator at the defined start value.
    assert_seed_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (lfsr_q == SEED && cnt_q == '0));

    // R8: the loop position stays inside the loop.
    assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/rxb_outreg.sv
// Output register. Captures every valid symbol in both modes. The error
// and ready flags come from the decoder in normal mode and from the
// compare of the held symbol against the generator in test mode.
// Assumes cmp_en is high only in test mode, for a symbol already held here.
module rxb_outreg #(
    parameter int DATA_W = 8,
    parameter int SYM_W  = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_special,
    input  logic              in_viol,
    input  logic              cmp_en,
    input  logic [SYM_W-1:0]  exp_sym,
    input  logic              wrap,
    output logic [DATA_W-1:0] out_data,
    output logic              out_special,
    output logic              out_err,
    output logic              out_ready
);
    logic [SYM_W-1:0] held_sym;
    logic             mismatch;

    // Feedback path: the registered symbol is what gets checked.
    assign held_sym = {out_special, out_data};
    assign mismatch = (held_sym != exp_sym);

    // Symbol capture on every valid byte, either mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data    <= '0;
            out_special <= 1'b0;
        end else if (in_valid) begin
            out_data    <= in_data;
            out_special <= in_special;
        end
    end

    // Error flag: compare result in test mode, decoder flag in normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_err <= 1'b0;
        end else if (test_en) begin
            out_err <= cmp_en && mismatch;
        end else if (in_valid) begin
            out_err <= in_viol;
        end
    end

    // Ready flag: one pulse as the last symbol of a loop is compared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_ready <= 1'b0;
        end else begin
            out_ready <= test_en && cmp_en && wrap;
        end
    end

    // R1: a valid symbol is visible at the outputs one edge later.
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data == $past(in_data) && out_special == $past(in_special)));

    // R2: normal mode forwards the decoder violation flag.
    assert_norm_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && in_valid) |=> (out_err == $past(in_viol)));

    // R2: no ready pulse outside test mode.
    assert_norm_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> !out_ready);

    // R6/R7: in test mode the error flag rises only from a compare.
    assert_quiet_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !cmp_en) |=> !out_err);

    // R8: ready is a single-cycle pulse.
    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |=> !out_ready);
endmodule

// File: rtl/rx_bist_checker.sv
// Receiver self-test checker top. Ties together the mode controller, the
// symbol generator and the output register. Results for a symbol in test
// mode appear one byte clock after the symbol reaches the outputs.
// Assumes one decoded symbol at most per byte clock.
module rx_bist_checker #(
    parameter int DATA_W = 8,
    parameter int TAP_HI = 8,
    parameter int TAP_LO = 4,
    parameter logic [DATA_W:0] SEED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_special,
    input  logic              in_viol,
    output logic [DATA_W-1:0] out_data,
    output logic              out_special,
    output logic              out_err,
    output logic              out_ready
);
    localparam int SYM_W    = DATA_W + 1;
    localparam int LOOP_LEN = (1 << SYM_W) - 1;

    logic             seed_load;
    logic             running;
    logic             cmp_pend;
    logic             cmp_en;
    logic [SYM_W-1:0] exp_sym;
    logic             wrap;

    // A pending compare only counts while test mode is still held.
    assign cmp_en = cmp_pend && test_en;

    rxb_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (test_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_special (in_special),
        .seed_load  (seed_load),
        .running    (running),
        .cmp_pend   (cmp_pend)
    );

    rxb_gen #(
        .SYM_W    (SYM_W),
        .SEED     (SEED),
        .TAP_HI   (TAP_HI),
        .TAP_LO   (TAP_LO),
        .LOOP_LEN (LOOP_LEN)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .step      (cmp_en),
        .exp_sym   (exp_sym),
        .wrap      (wrap)
    );

    rxb_outreg #(.DATA_W(DATA_W), .SYM_W(SYM_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_en     (test_en),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_special  (in_special),
        .in_viol     (in_viol),
        .cmp_en      (cmp_en),
        .exp_sym     (exp_sym),
        .wrap        (wrap),
        .out_data    (out_data),
        .out_special (out_special),
        .out_err     (out_err),
        .out_ready   (out_ready)
    );

    // R4: armed and idle in test mode means no error and no ready pulse.
    assert_armed_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !running && !cmp_pend) |=> (!out_err && !out_ready));

    // R8: a ready pulse only follows a cycle spent in test mode.
    assert_ready_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> $past(test_en));
endmodule

// File: tb/tb_rx_bist_checker.sv
// Self-checking bench: behavioural reference model compared every cycle.
module tb_rx_bist_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_special = 1'b0;
    logic       in_viol = 1'b0;
    logic [7:0] out_data;
    logic       out_special, out_err, out_ready;

    always #10 clk = ~clk;   // 50 MHz

    rx_bist_checker dut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .in_valid(in_valid),
        .in_data(in_data), .in_special(in_special), .in_viol(in_viol),
        .out_data(out_data), .out_special(out_special), .out_err(out_err),
        .out_ready(out_ready)
    );

    int    checks = 0, failures = 0, cyc = 0, rdy_seen = 0, run_bytes = 0;
    int    t_idx = 0;
    bit    t_run = 0, chk_on = 0, done = 0;
    string cur_req = "R1";
    int unsigned lcg = 32'h1234_5678;
    logic [8:0] seq [511];

    function automatic int unsigned rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg >> 8;
    endfunction

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic report();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Reference model (R1-R10): verdict decided on arrival, released one edge later.
    logic [7:0] m_data = '0;
    logic m_spec = 0, m_err = 0, m_ready = 0;
    int   m_mode = 0, m_idx = 0;   // 0 normal, 1 armed, 2 running
    bit   p_v = 0, p_mis = 0, p_wrap = 0;

    always @(posedge clk) begin
        logic [8:0] sym;
        cyc++;
        sym = {in_special, in_data};
        if (!rst_n) begin
            m_data = '0; m_spec = 0; m_err = 0; m_ready = 0;
            m_mode = 0; m_idx = 0; p_v = 0;
            chk_on = 1;
        end else begin
            if (test_en) begin
                m_err   = p_v && p_mis;
                m_ready = p_v && p_wrap;
            end else begin
                if (in_valid) m_err = in_viol;
                m_ready = 0;
            end
            p_v = test_en && (m_mode == 2) && in_valid;
            if (p_v) begin
                p_mis  = (sym != seq[m_idx]);
                p_wrap = (m_idx == 510);
                m_idx  = (m_idx + 1) % 511;
            end
            if (!test_en) m_mode = 0;
            else if (m_mode != 2 && in_valid && sym == 9'h000) begin
                m_mode = 2; m_idx = 0;
            end else if (m_mode == 0) m_mode = 1;
            if (in_valid) begin m_data = in_data; m_spec = in_special; end
        end
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL %s watchdog actual=%0d expected=%0d", cur_req, cyc, 20000);
            report();
        end
    end

    // Per-cycle comparison away from the active edge (reset values are R1).
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check("out_data", out_data, m_data);
            check("out_special", out_special, m_spec);
            check("out_err", out_err, m_err);
            check("out_ready", out_ready, m_ready);
            if (out_ready) rdy_seen++;
        end
    end

    task automatic put(input logic [8:0] sym, input logic viol);
        @(negedge clk);
        in_valid = 1'b1;
        {in_special, in_data} = sym;
        in_viol = viol;
        if (t_run) run_bytes++;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_viol  = rnd() % 2;
            {in_special, in_data} = 9'(rnd());
        end
    endtask

    // Send the next expected symbols, optionally with violations and gaps.
    task automatic good(input int n, input logic viol);
        for (int i = 0; i < n; i++) begin
            put(seq[t_idx], viol);
            t_idx = (t_idx + 1) % 511;
            if (rnd() % 7 == 0) gap(1 + rnd() % 2);
        end
    endtask

    initial begin
        logic [8:0] s;
        s = 9'h1FF;
        for (int i = 0; i < 511; i++) begin
            seq[i] = s;
            s = {s[7:0], s[8] ^ s[4]};
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: capture with gaps in normal mode
        cur_req = "R1";
        for (int i = 0; i < 20; i++) begin
            put(9'(rnd()), rnd() % 2);
            if (i % 3 == 0) gap(2);
        end
        // R2: violation flag forwarded, no ready
        cur_req = "R2";
        for (int i = 0; i < 20; i++) put(9'(rnd()), rnd() % 2);
        gap(2);

        // R4: armed, junk and violations, no errors
        cur_req = "R4";
        @(negedge clk); test_en = 1'b1; in_valid = 1'b0;
        for (int i = 0; i < 30; i++) put(9'(1 + rnd() % 511), rnd() % 2);
        gap(2);

        // R5: start code, then sequence from its first symbol
        cur_req = "R5";
        put(9'h000, 1'b0);
        t_run = 1; t_idx = 0;
        good(40, 1'b0);
        // R3: rest of the first loop
        cur_req = "R3";
        good(471, 1'b0);
        gap(3);
        check("ready after first loop", rdy_seen, 1);
        // R7: violations ignored while comparing
        cur_req = "R7";
        good(100, 1'b1);
        // R6: injected mismatches
        cur_req = "R6";
        for (int i = 0; i < 50; i++) begin
            if (i % 5 == 2) put(seq[t_idx] ^ 9'(1 + rnd() % 511), 1'b0);
            else put(seq[t_idx], 1'b0);
            t_idx = (t_idx + 1) % 511;
        end
        // R8: loop-complete pulses
        cur_req = "R8";
        good(1100 - run_bytes, 1'b0);
        gap(3);
        check("ready pulse count", rdy_seen, run_bytes / 511);
        // R9: start code mid-loop is compared, not a re-seed
        cur_req = "R9";
        put(9'h000, 1'b0);
        t_idx = (t_idx + 1) % 511;
        good(30, 1'b0);
        gap(2);
        // R10: exit, re-enter, wait for a fresh start code
        cur_req = "R10";
        @(negedge clk); test_en = 1'b0; in_valid = 1'b0;
        t_run = 0;
        for (int i = 0; i < 5; i++) put(9'(rnd()), rnd() % 2);
        @(negedge clk); test_en = 1'b1; in_valid = 1'b0;
        good(20, 1'b1);
        put(9'h000, 1'b0);
        t_idx = 0;
        good(30, 1'b0);
        gap(4);
        report();
    end
endmodule